// File: doc/BRIEF.md
# Pipelined SRAM Read/Write Turnaround Scheduler

This block sits between a request source and a pair of synchronous SRAM arrays, one holding tags and one holding data, which share a single bidirectional data bus per array. It accepts one read or write request at a time and presents it on the SRAM pins. It also times the output-enable strobe, when the memory drives the bus, and the write-data driver, when the controller drives the bus. It raises a stall toward the request source whenever the next request may not yet be placed on the pins.

Two timings are supported, chosen by `mode_pipe`. In pipelined mode an access occupies the pins for one cycle. Read data appears on the bus `RD_LAT` cycles after the address (two by default). Write data follows its address by one cycle, because the memory buffers one late write. A write that follows a read must therefore wait until the read data has left the bus and one idle cycle has passed for the bus to change direction. A read that follows a write never waits. In two-cycle mode every access holds the pins for two cycles, and the natural spacing already leaves room for the bus to turn. The mode input may only be changed while no access is in flight. The tag and data arrays always see identical timing.

Top module: `sram_turn_sched`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every select, write-enable, output-enable, drive, `rd_valid` and `req_stall` output is 0.
- R2: In pipelined mode, back-to-back reads and back-to-back writes are each accepted one per cycle without stall. Each accepted request appears on the pins, with its address and with write-enable equal to its write flag, exactly one cycle after acceptance, in request order.
- R3: In pipelined mode, a write requested directly after a read sees `req_stall` high for exactly two cycles, and its address reaches the pins three cycles after the read's address, which leaves two empty pin cycles.
- R4: A read requested directly after a write is accepted without any stall.
- R5: Output-enable is high only in the cycle when read data is on the bus: `RD_LAT` (2) cycles after the read address in pipelined mode, and the second pin cycle in two-cycle mode. `rd_valid` rises one cycle later, with the tag and data values that were on the bus in that cycle.
- R6: The controller drives a write's tag and data onto the bus exactly one cycle after the write address first appears, and in no other cycle.
- R7: Output-enable and the controller's drive are never high in the same cycle, and the drive is never high in the cycle directly after an output-enable cycle.
- R8: The tag and data arrays receive the same select, write-enable, output-enable, drive and address in every cycle.
- R9: In two-cycle mode, each accepted access holds the same address and write-enable on the pins for two cycles, and `req_stall` is high during the first of them. Back-to-back requests of any mix of reads and writes are spaced two cycles apart, so a write following a read gets no extra stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pipe | input | 1 | 1: pipelined one-cycle accesses; 0: two-cycle accesses. Change only when idle |
| req_valid | input | 1 | A request is offered |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | AW | Request address |
| req_tag | input | TW | Tag to write |
| req_data | input | DW | Data to write |
| req_stall | output | 1 | Request must be held this cycle |
| tag_addr | output | AW | Tag array address |
| tag_sel | output | 1 | Tag array access in this cycle |
| tag_we | output | 1 | Tag array write enable |
| tag_oe | output | 1 | Tag array drives its bus |
| tag_drive | output | 1 | Controller drives the tag bus |
| tag_wdata | output | TW | Tag write value (zero when not driving) |
| tag_rdata | input | TW | Tag bus value from the array |
| data_addr | output | AW | Data array address |
| data_sel | output | 1 | Data array access in this cycle |
| data_we | output | 1 | Data array write enable |
| data_oe | output | 1 | Data array drives its bus |
| data_drive | output | 1 | Controller drives the data bus |
| data_wdata | output | DW | Data write value (zero when not driving) |
| data_rdata | input | DW | Data bus value from the array |
| rd_valid | output | 1 | Read result available |
| rd_tag | output | TW | Captured tag |
| rd_data | output | DW | Captured data |

## Verification
A directed pipelined run of three reads followed by two writes distinguishes a correct two-cycle turnaround from a penalty of one or three cycles, and it also shows that the second write is not penalised. A write, read, read run confirms that the opposite transition costs nothing. A mixed run in two-cycle mode shows that reads and writes get the same spacing there. Random mixes with idle gaps in both modes then compare every pin cycle, every bus-direction strobe and every returned value against a bench memory model. These random runs expose misplaced strobes and lost or duplicated accesses that the fixed patterns would not reach.

// File: rtl/sts_pkg.sv
package sts_pkg;

   // What occupies the SRAM pins in the current cycle
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2
   } acc_e;

   // Position within a two-cycle access
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } phase_e;

   function automatic acc_e acc_kind(input logic valid, input logic write);
      if (!valid)     return ACC_NONE;
      else if (write) return ACC_WR;
      else            return ACC_RD;
   endfunction

endpackage

// File: rtl/sts_sched.sv
module sts_sched
   import sts_pkg::*;
#(
   parameter int RD_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_pipe,
   input  logic req_valid,
   input  logic req_write,
   output logic req_stall,
   output logic accept,
   output logic pin_sel,
   output logic pin_we,
   output logic oe_slot,
   output logic drv_slot
);

   localparam int WIN = RD_LAT - 1;   // history bits besides the current pin cycle that block a write

   acc_e   kind_q;
   phase_e ph_q;
   logic   wr_prev_q;
   logic   rd_now;
   logic [RD_LAT:1] hist_q;           // hist_q[k]: read on the pins k cycles ago

   assign rd_now = (kind_q == ACC_RD);

   for (genvar g = 1; g <= RD_LAT; g++) begin : g_hist
      if (g == 1) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q[g] <= 1'b0;
            else        hist_q[g] <= rd_now;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist_q[g] <= 1'b0;
            else        hist_q[g] <= hist_q[g-1];
         end
      end
   end

   logic rd_window;
   logic busy_first;
   logic stall_pipe;
   logic stall_two;
   logic hold;

   assign rd_window  = rd_now || (|hist_q[WIN:1]);
   assign busy_first = (kind_q != ACC_NONE) && (ph_q == PH_FIRST);
   assign stall_pipe = req_valid && req_write && rd_window;
   assign stall_two  = busy_first;
   assign req_stall  = mode_pipe ? stall_pipe : stall_two;
   assign accept     = req_valid && !req_stall;
   assign hold       = !mode_pipe && busy_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q    <= ACC_NONE;
         ph_q      <= PH_FIRST;
         wr_prev_q <= 1'b0;
      end else begin
         wr_prev_q <= (kind_q == ACC_WR);
         if (hold) begin
            ph_q <= PH_SECOND;
         end else begin
            ph_q   <= PH_FIRST;
            kind_q <= acc_kind(accept, req_write);
         end
      end
   end

   assign pin_sel  = (kind_q != ACC_NONE);
   assign pin_we   = (kind_q == ACC_WR);
   assign oe_slot  = mode_pipe ? hist_q[RD_LAT]
                               : (kind_q == ACC_RD) && (ph_q == PH_SECOND);
   assign drv_slot = mode_pipe ? wr_prev_q
                               : (kind_q == ACC_WR) && (ph_q == PH_SECOND);

endmodule

// File: rtl/sts_lane.sv
module sts_lane #(
   parameter int AW = 16,
   parameter int W  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [AW-1:0] req_addr,
   input  logic [W-1:0]  req_wdata,
   input  logic          pin_sel,
   input  logic          pin_we,
   input  logic          oe_slot,
   input  logic          drv_slot,
   input  logic [W-1:0]  bus_rdata,
   output logic [AW-1:0] sram_addr,
   output logic          sram_sel,
   output logic          sram_we,
   output logic          sram_oe,
   output logic          sram_drive,
   output logic [W-1:0]  sram_wdata,
   output logic          rvalid,
   output logic [W-1:0]  rdata
);

   logic [AW-1:0] addr_q;
   logic [W-1:0]  wd_q;      // value belonging to the access on the pins
   logic [W-1:0]  wd_late_q; // same value one cycle later, for the late write
   logic          rvalid_q;
   logic [W-1:0]  rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         wd_q      <= '0;
         wd_late_q <= '0;
      end else begin
         if (accept) begin
            addr_q <= req_addr;
            wd_q   <= req_wdata;
         end
         wd_late_q <= wd_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         rvalid_q <= oe_slot;
         if (oe_slot) rdata_q <= bus_rdata;
      end
   end

   assign sram_addr  = addr_q;
   assign sram_sel   = pin_sel;
   assign sram_we    = pin_we;
   assign sram_oe    = oe_slot;
   assign sram_drive = drv_slot;
   assign sram_wdata = drv_slot ? wd_late_q : '0;
   assign rvalid     = rvalid_q;
   assign rdata      = rdata_q;

endmodule

// File: rtl/sram_turn_sched.sv
module sram_turn_sched #(
   parameter int AW     = 16,
   parameter int TW     = 12,
   parameter int DW     = 32,
   parameter int RD_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_pipe,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [TW-1:0] req_tag,
   input  logic [DW-1:0] req_data,
   output logic          req_stall,
   output logic [AW-1:0] tag_addr,
   output logic          tag_sel,
   output logic          tag_we,
   output logic          tag_oe,
   output logic          tag_drive,
   output logic [TW-1:0] tag_wdata,
   input  logic [TW-1:0] tag_rdata,
   output logic [AW-1:0] data_addr,
   output logic          data_sel,
   output logic          data_we,
   output logic          data_oe,
   output logic          data_drive,
   output logic [DW-1:0] data_wdata,
   input  logic [DW-1:0] data_rdata,
   output logic          rd_valid,
   output logic [TW-1:0] rd_tag,
   output logic [DW-1:0] rd_data
);

   if (RD_LAT < 2 || RD_LAT > 8) begin : g_bad_lat
      $error("sram_turn_sched: RD_LAT must lie in 2..8");
   end
   if (AW < 1 || TW < 1 || DW < 1) begin : g_bad_width
      $error("sram_turn_sched: widths must be positive");
   end

   logic accept;
   logic pin_sel;
   logic pin_we;
   logic oe_slot;
   logic drv_slot;
   logic tag_rv;
   logic data_rv;

   sts_sched #(.RD_LAT(RD_LAT)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_pipe (mode_pipe),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_stall (req_stall),
      .accept    (accept),
      .pin_sel   (pin_sel),
      .pin_we    (pin_we),
      .oe_slot   (oe_slot),
      .drv_slot  (drv_slot)
   );

   sts_lane #(.AW(AW), .W(TW)) u_tag_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_tag),
      .pin_sel    (pin_sel),
      .pin_we     (pin_we),
      .oe_slot    (oe_slot),
      .drv_slot   (drv_slot),
      .bus_rdata  (tag_rdata),
      .sram_addr  (tag_addr),
      .sram_sel   (tag_sel),
      .sram_we    (tag_we),
      .sram_oe    (tag_oe),
      .sram_drive (tag_drive),
      .sram_wdata (tag_wdata),
      .rvalid     (tag_rv),
      .rdata      (rd_tag)
   );

   sts_lane #(.AW(AW), .W(DW)) u_data_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_data),
      .pin_sel    (pin_sel),
      .pin_we     (pin_we),
      .oe_slot    (oe_slot),
      .drv_slot   (drv_slot),
      .bus_rdata  (data_rdata),
      .sram_addr  (data_addr),
      .sram_sel   (data_sel),
      .sram_we    (data_we),
      .sram_oe    (data_oe),
      .sram_drive (data_drive),
      .sram_wdata (data_wdata),
      .rvalid     (data_rv),
      .rdata      (rd_data)
   );

   assign rd_valid = tag_rv && data_rv;

endmodule

// File: rtl/sram_turn_sched_chk.sv
module sram_turn_sched_chk #(
   parameter int AW     = 16,
   parameter int RD_LAT = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_pipe,
   input logic          req_valid,
   input logic          req_stall,
   input logic [AW-1:0] tag_addr,
   input logic          tag_sel,
   input logic          tag_we,
   input logic          tag_oe,
   input logic          tag_drive,
   input logic [AW-1:0] data_addr,
   input logic          data_sel,
   input logic          data_we,
   input logic          data_oe,
   input logic          data_drive,
   input logic          rd_valid
);

   logic [7:0]        rd_age;  // cycles since a read sat on the pins, minus one
   logic [RD_LAT-1:0] rdsh;    // rdsh[k]: read on the pins k+1 cycles ago

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_age <= 8'hff;
         rdsh   <= '0;
      end else begin
         if (data_sel && !data_we)  rd_age <= 8'd0;
         else if (rd_age != 8'hff)  rd_age <= rd_age + 8'd1;
         rdsh <= {rdsh[RD_LAT-2:0], data_sel && !data_we};
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!tag_sel && !data_sel && !tag_oe && !data_oe &&
                                        !tag_drive && !data_drive && !rd_valid)
            else $error("R1 strobes active during reset");
      end
   end

   assert_read_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pipe && data_sel && data_we) |-> (rd_age >= 8'(RD_LAT)));

   assert_oe_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_pipe |-> (data_oe == rdsh[RD_LAT-1]));

   assert_late_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pipe && data_sel && data_we) |=> data_drive);

   assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_oe && data_drive) && !(tag_oe && tag_drive));

   assert_dead_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |=> !data_drive);

   assert_lockstep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_sel == data_sel) && (tag_we == data_we) && (tag_oe == data_oe) &&
      (tag_drive == data_drive) && (tag_addr == data_addr));

   assert_two_cycle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_pipe && req_valid && !req_stall) |=>
         (data_sel && req_stall) ##1 (data_sel && $stable(data_addr) && $stable(data_we)));

endmodule

bind sram_turn_sched sram_turn_sched_chk #(.AW(AW), .RD_LAT(RD_LAT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_pipe  (mode_pipe),
   .req_valid  (req_valid),
   .req_stall  (req_stall),
   .tag_addr   (tag_addr),
   .tag_sel    (tag_sel),
   .tag_we     (tag_we),
   .tag_oe     (tag_oe),
   .tag_drive  (tag_drive),
   .data_addr  (data_addr),
   .data_sel   (data_sel),
   .data_we    (data_we),
   .data_oe    (data_oe),
   .data_drive (data_drive),
   .rd_valid   (rd_valid)
);

// File: tb/sim_sram_turn_sched.sv
module sim_sram_turn_sched;
   localparam int AW = 16;
   localparam int TW = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_pipe = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [TW-1:0] req_tag = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_stall;
   logic [AW-1:0] tag_addr, data_addr;
   logic          tag_sel, tag_we, tag_oe, tag_drive;
   logic          data_sel, data_we, data_oe, data_drive;
   logic [TW-1:0] tag_wdata, rd_tag;
   logic [DW-1:0] data_wdata, rd_data;
   logic [TW-1:0] tag_rdata = '0;
   logic [DW-1:0] data_rdata = '0;
   logic          rd_valid;

   sram_turn_sched u0 (
      .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_tag(req_tag), .req_data(req_data), .req_stall(req_stall),
      .tag_addr(tag_addr), .tag_sel(tag_sel), .tag_we(tag_we), .tag_oe(tag_oe),
      .tag_drive(tag_drive), .tag_wdata(tag_wdata), .tag_rdata(tag_rdata),
      .data_addr(data_addr), .data_sel(data_sel), .data_we(data_we), .data_oe(data_oe),
      .data_drive(data_drive), .data_wdata(data_wdata), .data_rdata(data_rdata),
      .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data)
   );

   always #4 clk = ~clk;   // 125 MHz

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit mon_en = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chkeq(input string req, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected-access queue, filled at acceptance
   logic [AW-1:0] q_addr[$];
   bit            q_wr[$];
   logic [TW-1:0] q_tag[$];
   logic [DW-1:0] q_data[$];

   // bench memory and per-cycle expectations
   logic [TW-1:0] mem_t[16];
   logic [DW-1:0] mem_d[16];
   bit            exp_oe[8];
   logic [AW-1:0] exp_oe_a[8];
   bit            exp_drv[8];
   logic [AW-1:0] exp_drv_a[8];
   logic [TW-1:0] exp_drv_t[8];
   logic [DW-1:0] exp_drv_d[8];
   bit            rv_pend = 1'b0;
   logic [TW-1:0] rv_t = '0;
   logic [DW-1:0] rv_d = '0;
   bit            prev_new = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   logic          prev_we = 1'b0;
   int            pin_log[$];

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem_t[i] = TW'(i * 37 + 5);
         mem_d[i] = DW'(i * 40503 + 11);
      end
      for (int i = 0; i < 8; i++) begin
         exp_oe[i] = 1'b0; exp_drv[i] = 1'b0;
         exp_oe_a[i] = '0; exp_drv_a[i] = '0; exp_drv_t[i] = '0; exp_drv_d[i] = '0;
      end
   end

   // monitor and SRAM model, away from the active edge
   always @(negedge clk) begin
      if (mon_en) begin
         int s;
         int s2;
         bit nw;
         logic [AW-1:0] a;
         bit w;
         s = cyc % 8;
         chkeq("R7", "oe and drive together", 64'(data_oe & data_drive) | 64'(tag_oe & tag_drive), 64'd0);
         chkeq("R8", "tag/data lockstep",
               64'({tag_sel, tag_we, tag_oe, tag_drive, tag_addr}),
               64'({data_sel, data_we, data_oe, data_drive, data_addr}));
         nw = data_sel && !(!mode_pipe && prev_new);
         if (data_sel && !nw) begin
            chkeq("R9", "second cycle address", 64'(data_addr), 64'(prev_addr));
            chkeq("R9", "second cycle write enable", 64'(data_we), 64'(prev_we));
         end
         if (nw) begin
            if (q_addr.size() == 0) begin
               chkeq("R2", "access with no request", 64'd1, 64'd0);
            end else begin
               a = q_addr.pop_front();
               w = q_wr.pop_front();
               chkeq("R2", "pin address", 64'(data_addr), 64'(a));
               chkeq("R2", "pin write enable", 64'(data_we), 64'(w));
               pin_log.push_back(cyc);
               if (w) begin
                  s2 = (cyc + 1) % 8;
                  exp_drv[s2] = 1'b1; exp_drv_a[s2] = a;
                  exp_drv_t[s2] = q_tag.pop_front(); exp_drv_d[s2] = q_data.pop_front();
               end else begin
                  void'(q_tag.pop_front()); void'(q_data.pop_front());
                  s2 = (cyc + (mode_pipe ? 2 : 1)) % 8;
                  exp_oe[s2] = 1'b1; exp_oe_a[s2] = a;
               end
            end
         end
         chkeq("R5", "output enable", 64'(data_oe), 64'(exp_oe[s]));
         chkeq("R6", "write drive", 64'(data_drive), 64'(exp_drv[s]));
         chkeq("R5", "rd_valid", 64'(rd_valid), 64'(rv_pend));
         if (rv_pend && rd_valid) begin
            chkeq("R5", "returned tag", 64'(rd_tag), 64'(rv_t));
            chkeq("R5", "returned data", 64'(rd_data), 64'(rv_d));
         end
         rv_pend = 1'b0;
         if (data_drive && exp_drv[s]) begin
            chkeq("R6", "tag write value", 64'(tag_wdata), 64'(exp_drv_t[s]));
            chkeq("R6", "data write value", 64'(data_wdata), 64'(exp_drv_d[s]));
            mem_t[exp_drv_a[s][3:0]] = tag_wdata;
            mem_d[exp_drv_a[s][3:0]] = data_wdata;
         end
         if (data_oe && exp_oe[s]) begin
            tag_rdata  = mem_t[exp_oe_a[s][3:0]];
            data_rdata = mem_d[exp_oe_a[s][3:0]];
            rv_t = tag_rdata; rv_d = data_rdata; rv_pend = 1'b1;
         end else begin
            tag_rdata  = '1;
            data_rdata = '1;
         end
         exp_oe[s] = 1'b0;
         exp_drv[s] = 1'b0;
         prev_new = nw;
         prev_addr = data_addr;
         prev_we = data_we;
      end
   end

   task automatic issue(input bit wr, input logic [AW-1:0] a, output int st);
      logic [31:0] r1;
      logic [31:0] r2;
      r1 = $urandom;
      r2 = $urandom;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a;
      req_tag = r1[TW-1:0]; req_data = r2[DW-1:0];
      #1;
      st = 0;
      while (req_stall) begin
         st++;
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      q_addr.push_back(a); q_wr.push_back(wr);
      q_tag.push_back(r1[TW-1:0]); q_data.push_back(r2[DW-1:0]);
      req_valid = 1'b0;
   endtask

   task automatic go_idle(input bit pipe);
      repeat (8) @(posedge clk);
      @(negedge clk);
      mode_pipe = pipe;
   endtask

   task automatic run_random(input int n);
      int st;
      logic [31:0] r;
      for (int k = 0; k < n; k++) begin
         r = $urandom;
         issue(r[0], AW'(r[7:4]), st);
         if (r[9:8] == 2'd3) repeat (int'(r[11:10])) @(posedge clk);
      end
   endtask

   initial begin
      int st[5];
      void'($urandom(32'd1337));
      // R1: quiet during reset
      repeat (3) @(negedge clk);
      chkeq("R1", "outputs during reset",
            64'({tag_sel, data_sel, tag_we, data_we, tag_oe, data_oe, tag_drive, data_drive, rd_valid, req_stall}),
            64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chkeq("R1", "outputs after reset",
            64'({tag_sel, data_sel, tag_oe, data_oe, tag_drive, data_drive, rd_valid, req_stall}),
            64'd0);
      mon_en = 1'b1;

      // three reads, two writes, pipelined
      pin_log.delete();
      issue(1'b0, 16'h0001, st[0]);
      issue(1'b0, 16'h0002, st[1]);
      issue(1'b0, 16'h0003, st[2]);
      issue(1'b1, 16'h0004, st[3]);
      issue(1'b1, 16'h0005, st[4]);
      repeat (6) @(posedge clk);
      chkeq("R2", "read stalls", 64'(st[0] + st[1] + st[2]), 64'd0);
      chkeq("R3", "read-to-write stalls", 64'(st[3]), 64'd2);
      chkeq("R2", "write-to-write stalls", 64'(st[4]), 64'd0);
      chkeq("R2", "pins logged", 64'(pin_log.size()), 64'd5);
      if (pin_log.size() == 5) begin
         chkeq("R2", "read spacing", 64'(pin_log[2] - pin_log[0]), 64'd2);
         chkeq("R3", "read-to-write pin gap", 64'(pin_log[3] - pin_log[2]), 64'd3);
         chkeq("R2", "write spacing", 64'(pin_log[4] - pin_log[3]), 64'd1);
      end

      // write then reads, pipelined; read back addresses just written
      pin_log.delete();
      issue(1'b1, 16'h0006, st[0]);
      issue(1'b0, 16'h0004, st[1]);
      issue(1'b0, 16'h0006, st[2]);
      repeat (6) @(posedge clk);
      chkeq("R4", "write-to-read stalls", 64'(st[1]), 64'd0);
      chkeq("R2", "read-to-read stalls", 64'(st[2]), 64'd0);
      if (pin_log.size() == 3)
         chkeq("R4", "write-to-read pin gap", 64'(pin_log[1] - pin_log[0]), 64'd1);
      else
         chkeq("R4", "pins logged", 64'(pin_log.size()), 64'd3);

      // two-cycle mode: mixed back-to-back
      go_idle(1'b0);
      pin_log.delete();
      issue(1'b0, 16'h0004, st[0]);
      issue(1'b1, 16'h0007, st[1]);
      issue(1'b0, 16'h0007, st[2]);
      issue(1'b1, 16'h0008, st[3]);
      repeat (6) @(posedge clk);
      chkeq("R9", "first stall", 64'(st[0]), 64'd0);
      chkeq("R9", "read-to-write stall", 64'(st[1]), 64'd1);
      chkeq("R9", "write-to-read stall", 64'(st[2]), 64'd1);
      chkeq("R9", "read-to-write stall again", 64'(st[3]), 64'd1);
      if (pin_log.size() == 4) begin
         chkeq("R9", "read-to-write pin gap", 64'(pin_log[1] - pin_log[0]), 64'd2);
         chkeq("R9", "write-to-read pin gap", 64'(pin_log[2] - pin_log[1]), 64'd2);
      end else begin
         chkeq("R9", "pins logged", 64'(pin_log.size()), 64'd4);
      end

      run_random(200);
      go_idle(1'b1);
      run_random(400);
      repeat (10) @(posedge clk);
      chkeq("R2", "requests left unissued", 64'(q_addr.size()), 64'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule